// File: doc/BRIEF.md
# Thermal Stepper Actuator Sequencer

This block steps an object along by driving four heated clamping elements in a fixed thermal order. Each step starts with all four elements heating together toward an upper setpoint. The elements are then cooled one at a time, first element 0, then 1, 2 and 3. Each element cools only down to a lower setpoint, which is the upper setpoint minus a programmed delta, and does not fall back toward ambient. An element that has already cooled stays regulated at the lower setpoint while the later ones take their turn. Once all four have cooled, the step is complete. The sequence then repeats until the requested number of steps has been made, and at that point every heater is switched off and the mechanics keep the position.

Each element's heater is driven by on/off hysteretic control around that element's current target. A phase moves on only after the temperature it watches has stayed within a tolerance band of its target for a programmed number of consecutive clock cycles. A per-phase timeout, an abort input and an absolute temperature limit each stop the run and raise a fault flag. The temperature readings come in as one sample per element per clock cycle.

Top module: `thermo_step_seq`

## Requirements
- R1: After reset, `heat_en`, `busy`, `done`, `fault` and `steps_done` are all 0. A `start` while not busy, with `step_req` not 0, latches `step_req`, clears `fault` and `steps_done`, and raises `busy` on the next cycle. In the first phase of every step, all elements have the upper setpoint `t_upper` as their target, so every cold element's heater turns on.
- R2: A phase ends only after its watched temperature has been within `t_tol` of its target for `settle_len` consecutive cycles. A single out-of-band sample restarts the count. In the common heating phase all four readings must be in band. In a cooling phase only the cooling element is watched.
- R3: The cooling phases follow the fixed order element 0, 1, 2, 3, and only one element cools at a time. The cooling element's target is `t_upper - t_delta`.
- R4: While element k cools, every element below k stays regulated at `t_upper - t_delta` and every element above k stays at `t_upper`.
- R5: Each heater turns on when its reading is below target minus `t_hyst` and turns off when its reading is above target plus `t_hyst`. Between those two thresholds it keeps its previous state.
- R6: `steps_done` rises by one after each complete step. When it reaches the latched request, `done` pulses high for one cycle, `busy` falls and all heaters go off.
- R7: A `start` with `step_req` equal to 0 pulses `done` on the next cycle and leaves `busy` low.
- R8: A `start` received while busy has no effect on the run or on `steps_done`.
- R9: While busy, an `abort` or any reading above `t_limit` forces all heaters off, clears `busy` and sets `fault` on the next cycle. `fault` then stays set until the next accepted `start`.
- R10: If a phase has not ended after `timeout_len` cycles, the run stops with `fault` set, as in R9. With the phase entered on cycle 0, the fault appears after cycle `timeout_len + 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, one cycle |
| abort | input | 1 | Stop the run and flag a fault |
| step_req | input | STEP_W | Number of steps to make, latched at start |
| t_upper | input | TEMP_W | Upper setpoint for the common heating phase |
| t_delta | input | TEMP_W | Drop below the upper setpoint that gives the lower setpoint |
| t_limit | input | TEMP_W | Absolute maximum reading allowed |
| t_hyst | input | TEMP_W | Half-width of the on/off hysteresis |
| t_tol | input | TEMP_W | Half-width of the settle band |
| settle_len | input | SETTLE_W | Consecutive in-band cycles needed to end a phase |
| timeout_len | input | TIME_W | Cycle limit for each phase |
| temp_flat | input | N_ELEM*TEMP_W | Readings; element i is in bits [i*TEMP_W +: TEMP_W] |
| heat_en | output | N_ELEM | Heater enables, bit i for element i |
| busy | output | 1 | A step sequence is running |
| done | output | 1 | One-cycle pulse when the requested steps are complete |
| fault | output | 1 | Abort, over-limit or timeout has stopped the run |
| steps_done | output | STEP_W | Steps completed in the current or last run |

## Verification
The bench builds the block with its default widths: four elements and 12-bit temperatures. It programs a settle length of 4, so the rule that a phase ends only after 4 consecutive in-band samples can be checked edge by edge. It also uses a timeout of 40 cycles, short enough that the exact cycle on which the fault appears can be checked. In some tests the bench forces the readings to chosen values, which lets it place them on either side of the hysteresis and band thresholds and infer each element's target from its heater state. For the full two-step run it closes the loop with a simple thermal model, so that the cooling order, the holding of earlier elements and the final switch-off can be observed over a whole sequence.

// File: rtl/thermo_step_pkg.sv
`timescale 1ns/1ps
// Shared types for the thermal stepper sequencer.
package thermo_step_pkg;
    // Sequencer phase: idle, common heat-up, or one element cooling.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HEAT = 2'd1,
        PH_COOL = 2'd2
    } phase_e;
endpackage

// File: rtl/thermo_step_hyst.sv
`timescale 1ns/1ps
// Hysteretic on/off regulator for one heater.
// Assumes: target and hyst are given so that their sum fits in TEMP_W+1 bits.
// The heater is cleared while en is low.
module thermo_step_hyst #(
    parameter int TEMP_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] target,
    input  logic [TEMP_W-1:0] hyst,
    output logic              heat
);
    localparam int EW = TEMP_W + 1;
    logic [EW-1:0] t_w, tgt_w, h_w;
    assign t_w   = {1'b0, temp};
    assign tgt_w = {1'b0, target};
    assign h_w   = {1'b0, hyst};

    // On below the lower threshold, off above the upper threshold, hold between.
    always_ff @(posedge clk) begin
        if (!rst_n)                 heat <= 1'b0;
        else if (!en)               heat <= 1'b0;
        else if (t_w + h_w < tgt_w) heat <= 1'b1;
        else if (t_w > tgt_w + h_w) heat <= 1'b0;
    end
endmodule

// File: rtl/thermo_step_settle.sv
`timescale 1ns/1ps
// Settle and timeout tracker for the current phase.
// It counts consecutive in-band cycles and the age of the phase.
// Both counters clear when the phase ends or when the sequencer is inactive.
module thermo_step_settle #(
    parameter int SETTLE_W = 8,
    parameter int TIME_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                in_band,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic [TIME_W-1:0]   timeout_len,
    output logic                advance,
    output logic                timeout
);
    logic [SETTLE_W-1:0] cnt_q;
    logic [TIME_W-1:0]   age_q;

    // The phase ends when this sample completes the run of in-band samples.
    assign advance = active && in_band &&
                     (({1'b0, cnt_q} + (SETTLE_W+1)'(1)) >= {1'b0, settle_len});
    assign timeout = active && !advance && (age_q >= timeout_len);

    // Consecutive in-band sample counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || advance) cnt_q <= '0;
        else if (in_band)                 cnt_q <= cnt_q + SETTLE_W'(1);
        else                              cnt_q <= '0;
    end

    // Cycles spent in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || advance) age_q <= '0;
        else if (!timeout)                age_q <= age_q + TIME_W'(1);
    end
endmodule

// File: rtl/thermo_step_seq.sv
`timescale 1ns/1ps
// Thermal stepper sequencer top.
// Each step is a common heat-up of all elements to t_upper, followed by
// cooling the elements one at a time, in index order, to t_upper - t_delta.
// Elements that have already cooled are held at that lower target.
// Assumes t_delta <= t_upper and one reading per element per cycle.
module thermo_step_seq
    import thermo_step_pkg::*;
#(
    parameter int N_ELEM   = 4,
    parameter int TEMP_W   = 12,
    parameter int STEP_W   = 8,
    parameter int SETTLE_W = 8,
    parameter int TIME_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       abort,
    input  logic [STEP_W-1:0]          step_req,
    input  logic [TEMP_W-1:0]          t_upper,
    input  logic [TEMP_W-1:0]          t_delta,
    input  logic [TEMP_W-1:0]          t_limit,
    input  logic [TEMP_W-1:0]          t_hyst,
    input  logic [TEMP_W-1:0]          t_tol,
    input  logic [SETTLE_W-1:0]        settle_len,
    input  logic [TIME_W-1:0]          timeout_len,
    input  logic [N_ELEM*TEMP_W-1:0]   temp_flat,
    output logic [N_ELEM-1:0]          heat_en,
    output logic                       busy,
    output logic                       done,
    output logic                       fault,
    output logic [STEP_W-1:0]          steps_done
);
    localparam int IDX_W = (N_ELEM > 1) ? $clog2(N_ELEM) : 1;
    localparam int EW    = TEMP_W + 1;

    phase_e            phase_q;
    logic [IDX_W-1:0]  idx_q;
    logic [STEP_W-1:0] req_q;
    logic [TEMP_W-1:0] t_lower;
    logic [N_ELEM-1:0] hit, hot, heat_q;
    logic running, band_now, advance, timeout, trip, start_ok;
    logic last_elem, last_step;

    assign t_lower   = t_upper - t_delta;
    assign running   = (phase_q != PH_IDLE);
    assign start_ok  = start && !running;
    assign last_elem = (idx_q == IDX_W'(N_ELEM - 1));
    assign last_step = ((steps_done + STEP_W'(1)) == req_q);

    // One regulator, band check and limit check per element.
    for (genvar g = 0; g < N_ELEM; g++) begin : g_elem
        logic [TEMP_W-1:0] temp_g, tgt_g;
        assign temp_g = temp_flat[g*TEMP_W +: TEMP_W];
        // Elements up to and including the cooling one aim at the lower setpoint.
        assign tgt_g  = (phase_q == PH_COOL && IDX_W'(g) <= idx_q) ? t_lower : t_upper;
        assign hit[g] = ({1'b0, temp_g} + {1'b0, t_tol} >= {1'b0, tgt_g}) &&
                        ({1'b0, temp_g} <= {1'b0, tgt_g} + EW'(t_tol));
        assign hot[g] = (temp_g > t_limit);
        thermo_step_hyst #(.TEMP_W(TEMP_W)) u_reg (
            .clk(clk), .rst_n(rst_n), .en(running),
            .temp(temp_g), .target(tgt_g), .hyst(t_hyst), .heat(heat_q[g])
        );
    end

    // The heat-up watches every element; a cooling phase watches only its element.
    assign band_now = (phase_q == PH_HEAT) ? (&hit) : hit[idx_q];
    assign trip     = running && (abort || (|hot) || timeout);

    thermo_step_settle #(.SETTLE_W(SETTLE_W), .TIME_W(TIME_W)) u_settle (
        .clk(clk), .rst_n(rst_n), .active(running), .in_band(band_now),
        .settle_len(settle_len), .timeout_len(timeout_len),
        .advance(advance), .timeout(timeout)
    );

    assign heat_en = heat_q & {N_ELEM{running}};
    assign busy    = running;

    // Phase sequencing, step counting, done pulse and fault latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            idx_q      <= '0;
            req_q      <= '0;
            steps_done <= '0;
            done       <= 1'b0;
            fault      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start_ok) begin
                fault      <= 1'b0;
                steps_done <= '0;
                req_q      <= step_req;
                idx_q      <= '0;
                if (step_req == '0) done    <= 1'b1;
                else                phase_q <= PH_HEAT;
            end else if (trip) begin
                phase_q <= PH_IDLE;
                fault   <= 1'b1;
            end else if (advance) begin
                case (phase_q)
                    PH_HEAT: begin
                        phase_q <= PH_COOL;
                        idx_q   <= '0;
                    end
                    PH_COOL: begin
                        if (last_elem) begin
                            steps_done <= steps_done + STEP_W'(1);
                            idx_q      <= '0;
                            if (last_step) begin
                                phase_q <= PH_IDLE;
                                done    <= 1'b1;
                            end else begin
                                phase_q <= PH_HEAT;
                            end
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/thermo_step_seq_chk.sv
`timescale 1ns/1ps
// Port-level property checker for the thermal stepper sequencer.
module thermo_step_seq_chk #(
    parameter int N_ELEM = 4,
    parameter int STEP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              abort,
    input logic [STEP_W-1:0] step_req,
    input logic [N_ELEM-1:0] heat_en,
    input logic              busy,
    input logic              done,
    input logic              fault,
    input logic [STEP_W-1:0] steps_done
);
    // R1: an accepted nonzero start begins a clean run.
    p_start_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && step_req != '0 |=> busy && !fault && steps_done == '0);

    // R6: done is a single-cycle pulse.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: on done the run is over and the heaters are off.
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && heat_en == '0);

    // R6: the step count moves by at most one per cycle during a run.
    p_step_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (steps_done == $past(steps_done)) ||
                 (steps_done == $past(steps_done) + STEP_W'(1)));

    // R7: a zero request only pulses done.
    p_zero_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && step_req == '0 |=> done && !busy);

    // R8: a start during a run does not clear the progress.
    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && steps_done != '0 |=> steps_done != '0);

    // R9: abort while running stops everything and flags a fault.
    p_abort_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && abort |=> !busy && fault && heat_en == '0);

    // R9: the fault stays set until a start arrives.
    p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault && !start |=> fault);

    // R9: no heater is on while a fault is reported.
    p_fault_cold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> heat_en == '0);
endmodule

bind thermo_step_seq thermo_step_seq_chk #(.N_ELEM(N_ELEM), .STEP_W(STEP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .step_req(step_req),
    .heat_en(heat_en), .busy(busy), .done(done), .fault(fault),
    .steps_done(steps_done)
);

// File: tb/thermo_step_seq_test.sv
`timescale 1ns/1ps
// Directed bench: forced readings for threshold tests, a thermal model for full runs.
module thermo_step_seq_test;
    localparam int N = 4;
    localparam int TW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, abort = 1'b0;
    logic [7:0]  step_req = '0;
    logic [TW-1:0] t_upper = 12'd400, t_delta = 12'd100, t_limit = 12'd900;
    logic [TW-1:0] t_hyst = 12'd8, t_tol = 12'd4;
    logic [7:0]  settle_len = 8'd4;
    logic [15:0] timeout_len = 16'd3000;
    logic [N*TW-1:0] temp_flat;
    logic [N-1:0] heat_en;
    logic busy, done, fault;
    logic [7:0] steps_done;

    int tp [N];
    bit plant_on = 1'b0;
    int tests = 0, fails = 0;

    assign temp_flat = {TW'(tp[3]), TW'(tp[2]), TW'(tp[1]), TW'(tp[0])};

    always #10 clk = ~clk;

    thermo_step_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .step_req(step_req),
        .t_upper(t_upper), .t_delta(t_delta), .t_limit(t_limit), .t_hyst(t_hyst),
        .t_tol(t_tol), .settle_len(settle_len), .timeout_len(timeout_len),
        .temp_flat(temp_flat), .heat_en(heat_en), .busy(busy), .done(done),
        .fault(fault), .steps_done(steps_done)
    );

    task automatic check(input string req, input bit ok, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock; the model updates away from the active edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (plant_on)
            for (int i = 0; i < N; i++) begin
                if (heat_en[i]) tp[i] = tp[i] + 2;
                else if (tp[i] > 100) tp[i] = tp[i] - 2;
            end
    endtask

    task automatic set_all(input int v);
        for (int i = 0; i < N; i++) tp[i] = v;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R1 reset heat_en", heat_en == 0, heat_en, 0);
        check("R1 reset busy", busy == 0, busy, 0);
        check("R1 reset done", done == 0, done, 0);
        check("R1 reset fault", fault == 0, fault, 0);
        check("R1 reset steps_done", steps_done == 0, steps_done, 0);
    endtask

    task automatic t_zero_req();
        step_req = 8'd0;
        pulse_start();
        check("R7 zero request done pulse", done == 1, done, 1);
        check("R7 zero request not busy", busy == 0, busy, 0);
        tick();
        check("R7 done lasts one cycle", done == 0, done, 0);
    endtask

    // Forced readings: settle counting, hysteresis, targets, abort.
    task automatic t_forced_thresholds();
        plant_on = 1'b0;
        t_hyst = 12'd8; t_tol = 12'd4; settle_len = 8'd4; timeout_len = 16'd3000;
        step_req = 8'd1;
        set_all(200);
        pulse_start();
        check("R1 busy after start", busy == 1, busy, 1);
        tick();
        check("R1 all heaters on in heat-up", heat_en == 4'hF, heat_en, 15);
        set_all(400);
        repeat (2) tick();
        check("R5 hold inside hysteresis", heat_en == 4'hF, heat_en, 15);
        set_all(394);
        repeat (5) tick();
        check("R2 out of band keeps heat-up", heat_en == 4'hF, heat_en, 15);
        set_all(400);
        repeat (3) tick();
        check("R2 three in-band samples not enough", heat_en == 4'hF, heat_en, 15);
        tick();
        check("R2 fourth sample ends phase next", heat_en == 4'hF, heat_en, 15);
        tick();
        check("R3 element 0 cools first", heat_en == 4'b1110, heat_en, 14);
        set_all(410);
        tick();
        check("R5 off above upper threshold", heat_en == 4'h0, heat_en, 0);
        tp[0] = 291; tp[1] = 391; tp[2] = 391; tp[3] = 391;
        tick();
        check("R5 on below lower threshold", heat_en == 4'hF, heat_en, 15);
        tp[0] = 300; tp[1] = 400; tp[2] = 400; tp[3] = 400;
        repeat (4) tick();
        tp[0] = 310;
        tick();
        check("R4 held low, later elements high", heat_en == 4'b1100, heat_en, 12);
        abort = 1'b1;
        tick();
        abort = 1'b0;
        check("R9 abort clears busy", busy == 0, busy, 0);
        check("R9 abort sets fault", fault == 1, fault, 1);
        check("R9 abort heaters off", heat_en == 0, heat_en, 0);
        repeat (3) tick();
        check("R9 fault holds", fault == 1, fault, 1);
    endtask

    task automatic t_over_limit();
        plant_on = 1'b0;
        step_req = 8'd1;
        set_all(200);
        pulse_start();
        check("R9 start clears fault", fault == 0, fault, 0);
        tick();
        tp[2] = 901;
        tick();
        check("R9 over-limit fault", fault == 1, fault, 1);
        check("R9 over-limit not busy", busy == 0, busy, 0);
        check("R9 over-limit heaters off", heat_en == 0, heat_en, 0);
    endtask

    task automatic t_timeout();
        int n;
        plant_on = 1'b0;
        timeout_len = 16'd40;
        step_req = 8'd1;
        set_all(200);
        pulse_start();
        n = 0;
        while (!fault && n < 100) begin
            tick();
            n++;
        end
        check("R10 timeout fault cycle", n == 41, n, 41);
        check("R10 timeout stops run", busy == 0, busy, 0);
        timeout_len = 16'd3000;
    endtask

    // Closed loop with the thermal model: two full steps.
    task automatic t_full_run();
        int order [8];
        int nlog = 0, viol = 0, ndone = 0, n = 0;
        int prev [N];
        bit poked = 1'b0;
        plant_on = 1'b1;
        t_hyst = 12'd4; t_tol = 12'd10; settle_len = 8'd4; timeout_len = 16'd3000;
        step_req = 8'd2;
        set_all(100);
        pulse_start();
        while ((busy || n == 0) && n < 5000) begin
            for (int i = 0; i < N; i++) prev[i] = tp[i];
            if (steps_done == 1 && !poked) start = 1'b1;
            tick();
            if (start) begin
                start = 1'b0;
                poked = 1'b1;
                check("R8 start while busy ignored", busy == 1 && steps_done == 1,
                      steps_done, 1);
            end
            if (done) ndone++;
            n++;
            for (int i = 0; i < N; i++) begin
                if (prev[i] >= 350 && tp[i] < 350) begin
                    if (nlog < 8) order[nlog] = i;
                    nlog++;
                end
                if (tp[i] < prev[i] && tp[i] > 312 && tp[i] < 388) begin
                    for (int j = 0; j < N; j++) begin
                        if (j < i && (tp[j] > 312 || tp[j] < 288)) viol++;
                        if (j > i && tp[j] < 388) viol++;
                    end
                end
            end
        end
        check("R3 eight cooling events", nlog == 8, nlog, 8);
        for (int k = 0; k < 8; k++)
            if (k < nlog) check("R3 cooling order", order[k] == k % 4, order[k], k % 4);
        check("R4 held and waiting elements stay put", viol == 0, viol, 0);
        check("R6 steps completed", steps_done == 2, steps_done, 2);
        check("R6 single done pulse", ndone == 1, ndone, 1);
        check("R6 heaters off at end", heat_en == 0, heat_en, 0);
        check("R6 not busy at end", busy == 0, busy, 0);
        plant_on = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        set_all(100);
        t_reset();
        t_zero_req();
        t_forced_thresholds();
        t_over_limit();
        t_timeout();
        t_full_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule